// File: doc/BRIEF.md
# Full-Period LFSR Position Counter

This block is a step counter whose state register advances as a linear feedback shift register rather than through a binary adder. The feedback is maximal-length for the chosen width, and a correction term adds the one value the plain shift register can never reach, so the register passes through all 2^WIDTH values once per full period. Compared with a binary counter of the same width, the next-state logic is a parity tree and one zero detector, with no carry chain.

Positions are set as integers: the first step of the interval, its last step, and one marked step. Each position is turned into its register pattern while the design is elaborated, by running the sequence forward from the seed that many times. In hardware the block only compares the register against these fixed patterns. It counts one step on each enabled clock. On the step after the last position it loads the first position again, so it works as a repeating interval counter, for example for video line or frame timing.

Top module: `lfsr_pos_counter`

## Requirements
- R1: A synchronous reset loads the pattern of START_POS and clears wrap. Position 0 has the pattern 1, which is every bit low except bit 0.
- R2: Each clock with en high moves the state one position forward. The register shifts toward the MSB (new state[WIDTH-1:1] = old state[WIDTH-2:0]). The new bit 0 is the parity of the bits picked by the width's tap mask, XORed with a flag that is high when the old bits [WIDTH-2:0] are all zero.
- R3: With START_POS = 0 and END_POS = 2^WIDTH-1, the register shows every WIDTH-bit value exactly once over 2^WIDTH enabled steps and then returns to the pattern 1.
- R4: When en is high and the state equals the END_POS pattern, the next state is the START_POS pattern and wrap is high for exactly that one cycle. At every other time wrap is low.
- R5: While en is low, the state holds its value and wrap is low.
- R6: hit is combinational. It is high in the same cycle that the state equals the MATCH_POS pattern, and low in every other cycle.
- R7: For any interval, the state at position k equals the value that a free-running instance of the same width shows k steps after its seed.
- R8: The all-zeros value, which locks up the plain shift register, occurs at position 2^WIDTH-1, the last position before the sequence returns to the pattern 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, one step per clock |
| cnt_state | output | WIDTH | Raw shift-register state |
| hit | output | 1 | High while the state is at MATCH_POS |
| wrap | output | 1 | One-cycle pulse on the reload to START_POS |

## Verification
A wrong tap or a broken zero-splice term shows at cnt_state as a repeated value or a period other than 2^WIDTH. This appears within one full period, and it shows earlier, on the next enabled clock, when a shifted bit is lost. A mistranslated position pattern moves hit or wrap away from the position held by a binary reference count, or loads the wrong value on reset, so the error is visible in the first cycle at that position. Errors in the enable or reload logic show on the first idle cycle or the first wrap.

// File: rtl/lfsr_pos_pkg.sv
package lfsr_pos_pkg;

  localparam int unsigned MIN_W = 4;
  localparam int unsigned MAX_W = 16;

  // Maximal-length tap masks, bit i means register bit i feeds the parity.
  function automatic logic [MAX_W-1:0] tap_mask(input int unsigned w);
    logic [MAX_W-1:0] m;
    case (w)
      4:       m = 16'h000C;
      5:       m = 16'h0014;
      6:       m = 16'h0030;
      7:       m = 16'h0060;
      8:       m = 16'h00B8;
      9:       m = 16'h0110;
      10:      m = 16'h0240;
      11:      m = 16'h0500;
      12:      m = 16'h0829;
      13:      m = 16'h100D;
      14:      m = 16'h2015;
      15:      m = 16'h6000;
      16:      m = 16'hD008;
      default: m = 16'h0000;
    endcase
    return m;
  endfunction

  // One forward step of the full-period sequence, evaluated at elaboration.
  function automatic logic [MAX_W-1:0] lfsr_advance(input logic [MAX_W-1:0] s,
                                                     input int unsigned w);
    logic [MAX_W-1:0] low_m;
    logic [MAX_W-1:0] full_m;
    logic             fb;
    low_m  = {MAX_W{1'b1}} >> (MAX_W - w + 1);
    full_m = {MAX_W{1'b1}} >> (MAX_W - w);
    fb     = (^(s & tap_mask(w))) ^ ((s & low_m) == '0);
    return ((s << 1) | {{(MAX_W-1){1'b0}}, fb}) & full_m;
  endfunction

  // Position-to-pattern translation: iterate from the seed.
  function automatic logic [MAX_W-1:0] pos_to_pattern(input int unsigned pos,
                                                       input int unsigned w);
    logic [MAX_W-1:0] s;
    s = {{(MAX_W-1){1'b0}}, 1'b1};
    for (int unsigned k = 0; k < pos; k++) s = lfsr_advance(s, w);
    return s;
  endfunction

endpackage

// File: rtl/lfsr_next_state.sv
module lfsr_next_state
  import lfsr_pos_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [MAX_W-1:0] MASK_ALL = tap_mask(WIDTH);
  localparam logic [WIDTH-1:0] MASK     = MASK_ALL[WIDTH-1:0];

  generate
    if (WIDTH < MIN_W || WIDTH > MAX_W) begin : g_width_bad
      $error("lfsr_next_state: WIDTH outside supported range");
    end
  endgenerate

  logic parity;
  logic low_zero;

  assign parity   = ^(cur & MASK);
  assign low_zero = (cur[WIDTH-2:0] == '0);
  assign nxt      = {cur[WIDTH-2:0], parity ^ low_zero};

endmodule

// File: rtl/lfsr_pattern_cmp.sv
module lfsr_pattern_cmp
  import lfsr_pos_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned POS   = 0
) (
  input  logic [WIDTH-1:0] cur,
  output logic             eq
);

  localparam logic [MAX_W-1:0] PAT_ALL = pos_to_pattern(POS, WIDTH);
  localparam logic [WIDTH-1:0] PAT     = PAT_ALL[WIDTH-1:0];

  assign eq = (cur == PAT);

endmodule

// File: rtl/lfsr_pos_counter.sv
module lfsr_pos_counter
  import lfsr_pos_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned START_POS = 0,
  parameter int unsigned END_POS   = (1 << WIDTH) - 1,
  parameter int unsigned MATCH_POS = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] cnt_state,
  output logic             hit,
  output logic             wrap
);

  localparam logic [MAX_W-1:0] START_ALL = pos_to_pattern(START_POS, WIDTH);
  localparam logic [WIDTH-1:0] START_PAT = START_ALL[WIDTH-1:0];

  logic [WIDTH-1:0] step_nxt;
  logic             at_end;
  logic             at_mark;

  lfsr_next_state #(.WIDTH(WIDTH)) u_step (
    .cur (cnt_state),
    .nxt (step_nxt)
  );

  lfsr_pattern_cmp #(.WIDTH(WIDTH), .POS(END_POS)) u_end_cmp (
    .cur (cnt_state),
    .eq  (at_end)
  );

  lfsr_pattern_cmp #(.WIDTH(WIDTH), .POS(MATCH_POS)) u_mark_cmp (
    .cur (cnt_state),
    .eq  (at_mark)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_state <= START_PAT;
      wrap      <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (en) begin
        if (at_end) begin
          cnt_state <= START_PAT;
          wrap      <= 1'b1;
        end else begin
          cnt_state <= step_nxt;
        end
      end
    end
  end

  assign hit = at_mark;

endmodule

// File: rtl/lfsr_pos_counter_chk.sv
module lfsr_pos_counter_chk
  import lfsr_pos_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned START_POS = 0,
  parameter int unsigned END_POS   = (1 << WIDTH) - 1
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] cnt_state,
  input logic             wrap
);

  localparam logic [MAX_W-1:0] S_ALL = pos_to_pattern(START_POS, WIDTH);
  localparam logic [MAX_W-1:0] E_ALL = pos_to_pattern(END_POS, WIDTH);
  localparam logic [WIDTH-1:0] S_PAT = S_ALL[WIDTH-1:0];
  localparam logic [WIDTH-1:0] E_PAT = E_ALL[WIDTH-1:0];

  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  // R1
  rst_load_chk: assert property (@(posedge clk) disable iff (rst)
    seen && $past(rst) |-> (cnt_state == S_PAT) && !wrap);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && !$past(en) |-> $stable(cnt_state) && !wrap);

  // R4
  wrap_src_chk: assert property (@(posedge clk) disable iff (rst)
    seen && wrap |-> $past(en) && ($past(cnt_state) == E_PAT) && (cnt_state == S_PAT));

  // R4
  wrap_due_chk: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(en) && ($past(cnt_state) == E_PAT) |-> wrap);

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(en) && !wrap |->
      cnt_state[WIDTH-1:1] == $past(cnt_state[WIDTH-2:0]));

endmodule

bind lfsr_pos_counter lfsr_pos_counter_chk #(
  .WIDTH(WIDTH), .START_POS(START_POS), .END_POS(END_POS)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .cnt_state(cnt_state), .wrap(wrap)
);

// File: tb/lfsr_pos_counter_bench.sv
module lfsr_pos_counter_bench;

  localparam int W      = 8;
  localparam int PERIOD = 1 << W;
  localparam int A_START = 5;
  localparam int A_END   = 200;
  localparam int A_MARK  = 77;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_a = 1'b0;
  logic en_f = 1'b0;
  logic [W-1:0] st_a, st_f;
  logic hit_a, hit_f, wrap_a, wrap_f;

  int n_tests = 0;
  int n_fail  = 0;

  logic [W-1:0] pat [PERIOD];
  bit           seen_val [PERIOD];

  always #2 clk = ~clk;

  lfsr_pos_counter #(.WIDTH(W), .START_POS(A_START), .END_POS(A_END),
                     .MATCH_POS(A_MARK)) u_lfsr_pos_counter (
    .clk(clk), .rst(rst), .en(en_a), .cnt_state(st_a), .hit(hit_a), .wrap(wrap_a)
  );

  lfsr_pos_counter #(.WIDTH(W), .START_POS(0), .END_POS(PERIOD-1),
                     .MATCH_POS(0)) u_lfsr_pos_counter_full (
    .clk(clk), .rst(rst), .en(en_f), .cnt_state(st_f), .hit(hit_f), .wrap(wrap_f)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] prev_f, hold_a;
    int ref_pos;
    bit exp_wrap;
    bit e;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: seed pattern is 1 for position 0
    chk(st_f == 1, "R1 seed", st_f, 1);
    chk(wrap_f == 0 && wrap_a == 0, "R1 wrap clear", wrap_f + wrap_a, 0);
    chk(hit_f == 1, "R6 hit at pos 0", hit_f, 1);

    for (int i = 0; i < PERIOD; i++) seen_val[i] = 0;
    pat[0] = st_f;
    seen_val[st_f] = 1;
    prev_f = st_f;
    hold_a = st_a;

    en_f = 1'b1;
    for (int k = 1; k <= PERIOD; k++) begin
      @(posedge clk); #1;
      if (k < PERIOD) begin
        chk(!seen_val[st_f], "R3 unique", st_f, -1);
        seen_val[st_f] = 1;
        pat[k] = st_f;
        chk(st_f[W-1:1] == prev_f[W-2:0], "R2 shift", st_f[W-1:1], prev_f[W-2:0]);
        chk(wrap_f == 0, "R4 no early wrap", wrap_f, 0);
        chk(hit_f == 0, "R6 hit low", hit_f, 0);
        if (k == PERIOD - 1) chk(st_f == 0, "R8 zero at last pos", st_f, 0);
      end else begin
        chk(st_f == 1, "R3 return to seed", st_f, 1);
        chk(wrap_f == 1, "R4 wrap on reload", wrap_f, 1);
      end
      // R5: idle instance holds
      chk(st_a == hold_a && wrap_a == 0, "R5 idle hold", st_a, hold_a);
      prev_f = st_f;
    end
    en_f = 1'b0;
    @(posedge clk); #1;
    chk(st_f == prev_f, "R5 hold after disable", st_f, prev_f);
    chk(wrap_f == 0, "R5 wrap low when idle", wrap_f, 0);

    // R1 / R7: interval instance reset pattern is position START of the full sequence
    chk(st_a == pat[A_START], "R7 start pattern", st_a, pat[A_START]);
    chk(hit_a == 0, "R6 hit low at start", hit_a, 0);

    ref_pos = A_START;
    for (int c = 0; c < 700; c++) begin
      if (c == 400) begin
        rst = 1'b1; en_a = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        ref_pos = A_START;
        chk(st_a == pat[A_START], "R1 mid-run reset", st_a, pat[A_START]);
        chk(wrap_a == 0, "R1 wrap cleared", wrap_a, 0);
      end
      e = !((c % 7) == 3) && !(c > 250 && c < 260);
      en_a = e;
      @(posedge clk); #1;
      exp_wrap = 0;
      if (e) begin
        if (ref_pos == A_END) begin
          ref_pos = A_START;
          exp_wrap = 1;
        end else begin
          ref_pos++;
        end
      end
      chk(st_a == pat[ref_pos], "R7 state vs position", st_a, pat[ref_pos]);
      chk(wrap_a == exp_wrap, "R4 wrap", wrap_a, exp_wrap);
      chk(hit_a == (ref_pos == A_MARK), "R6 hit", hit_a, ref_pos == A_MARK);
    end
    en_a = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule